// File: doc/BRIEF.md
# Nine-Bit FIFO with Rewind and Chain Token

This block is a first-in first-out buffer of 9-bit words. It has active-low write and read strobes that are sampled by one system clock. Each access happens on the falling edge of its strobe: one word per falling edge, however long the strobe stays low. Flags for empty, full and half full keep a producer from overrunning the buffer and a consumer from underrunning it. The read data appears on a registered bus. A separate enable goes high while the read strobe is low and stands in for a tri-state output.

The mode input selects between two setups. In standalone mode, the shared flag pin shows half full. An active-low rewind input moves the read side back to the first location, so data already stored can be read again. In chain mode, several devices form one deeper buffer:
- Each device holds a write token and a read token.
- The device marked as first-load holds both tokens after reset.
- The shared pin pulses for one cycle when the device accesses its last location, and that token then moves on.
- A pulse on the expansion input gives this device the write token if it does not hold it, and the read token otherwise.

Top module: `fifo9_rewind`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers clear. After reset, `empty`=1, `full`=0 and `dout`=0. In standalone mode `hf_xo`=0.
- R2: A word on `din` is stored at the clock edge where `wr_n` is sampled low after being sampled high. Keeping `wr_n` low stores no further words.
- R3: At the clock edge where `rd_n` is first sampled low, the oldest unread word is loaded into `dout`. Words come out in the order they were written.
- R4: While `full` is 1 (occupancy equals DEPTH), a write edge is ignored and stored data is not changed.
- R5: While `empty` is 1 (occupancy 0), a read edge is ignored and `dout` keeps its value.
- R6: In standalone mode, `hf_xo` is 1 exactly when occupancy is at least DEPTH/2.
- R7: `dout_oe` equals the inverse of `rd_n` in every cycle.
- R8: In standalone mode, if `rt_n`=0 while `wr_n`=1 and `rd_n`=1 at a clock edge, the read position returns to location 0. Occupancy then becomes the number of words written since reset, capped at DEPTH.
- R9: A low `rt_n` has no effect in chain mode, or while either strobe is low.
- R10: In chain mode (`mode_chain`=1), `hf_xo` is high for the one cycle after a write to location DEPTH-1 or a read from location DEPTH-1.
- R11: In chain mode, a device ignores write edges without the write token and read edges without the read token. `first_load`=1 at reset gives it both tokens; `first_load`=0 gives it none. An access to location DEPTH-1 gives up that token. A one-cycle `xi` pulse grants the write token if it is absent, and the read token otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_chain | input | 1 | 0 standalone, 1 chain (depth expansion) |
| first_load | input | 1 | Device starts holding both tokens after reset |
| xi | input | 1 | Token pulse from the previous device |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind request |
| din | input | 9 | Write data |
| dout | output | 9 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| hf_xo | output | 1 | Half full (standalone) or token pulse out (chain) |

## Verification
Embedded assertions check on every cycle that a full buffer without a read keeps its write pointer and that an empty buffer keeps its read pointer. They also check that a rewind leaves the read pointer at zero with occupancy equal to the count of words written so far, that a device without the write token never moves its write pointer, and that the token pulse follows an access to the last location. Other behaviours can only be shown by the bench's scenarios running against its queue model:
- data order through a wrap;
- a rewind that is refused while a strobe is low;
- writes refused without a token;
- the token returned by an `xi` pulse.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
    parameter int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } mode_e;

    // Raw access requests, before flag and token gating
    typedef struct packed {
        logic wr;
        logic rd;
        logic rewind;
    } req_t;

    function automatic bit depth_ok(int d);
        return (d == 256) || (d == 512) || (d == 1024) || (d == 2048) || (d == 4096);
    endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic last_q;
        always_ff @(posedge clk) begin
            if (rst) last_q <= 1'b1;
            else     last_q <= strobe_n[i];
        end
        assign fall[i] = last_q & ~strobe_n[i];
    end
endmodule

// File: rtl/fifo9_mem.sv
module fifo9_mem
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  req_t          req,
    input  mode_e         mode,
    input  logic          wr_tok,
    input  logic          rd_tok,
    output logic          we,
    output logic          re,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          w_last,
    output logic          r_last,
    output logic          empty,
    output logic          full,
    output logic          half
);
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, wtot;
    logic          rewind;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign half   = (cnt >= CW'(DEPTH / 2));
    assign we     = req.wr && !full  && ((mode == MODE_SOLO) || wr_tok);
    assign re     = req.rd && !empty && ((mode == MODE_SOLO) || rd_tok);
    assign rewind = req.rewind && (mode == MODE_SOLO);
    assign waddr  = wptr;
    assign raddr  = rptr;
    assign w_last = (wptr == AW'(DEPTH - 1));
    assign r_last = (rptr == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            wtot <= '0;
        end else begin
            if (we) begin
                wptr <= wptr + 1'b1;
                if (wtot != CW'(DEPTH)) wtot <= wtot + 1'b1;
            end
            if (rewind) begin
                rptr <= '0;
                cnt  <= wtot;
            end else begin
                if (re) rptr <= rptr + 1'b1;
                cnt <= cnt + CW'(we) - CW'(re);
            end
        end
    end

    // R4: a full buffer with no read leaves the write pointer alone
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && !re) |=> $stable(wptr));
    // R5: an empty buffer does not advance its read pointer
    a_r5_no_underrun: assert property (@(posedge clk) disable iff (rst)
        (empty && !rewind) |=> $stable(rptr));
    // R8: rewind lands at location zero with occupancy = words written
    a_r8_rewind_target: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rptr == '0) && (cnt == $past(wtot)));
    // R11: without the write token in chain mode the write pointer holds
    a_r11_no_token_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && !wr_tok) |=> $stable(wptr));
endmodule

// File: rtl/fifo9_xtok.sv
module fifo9_xtok
    import fifo9_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  first_load,
    input  logic  xi,
    input  logic  we,
    input  logic  re,
    input  logic  w_last,
    input  logic  r_last,
    output logic  wr_tok,
    output logic  rd_tok,
    output logic  xo
);
    logic w_end, r_end;
    assign w_end = we && w_last;
    assign r_end = re && r_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_tok <= first_load;
            rd_tok <= first_load;
            xo     <= 1'b0;
        end else begin
            xo <= w_end || r_end;
            if (mode == MODE_CHAIN) begin
                if (w_end)            wr_tok <= 1'b0;
                else if (xi && !wr_tok) wr_tok <= 1'b1;
                if (r_end)            rd_tok <= 1'b0;
                else if (xi && wr_tok)  rd_tok <= 1'b1;
            end
        end
    end

    // R10: the last-location write is followed by a token pulse
    a_r10_xo_after_last: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && w_end) |=> xo);
    // R11: the last-location write gives up the write token
    a_r11_token_release: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CHAIN && w_end) |=> !wr_tok);
endmodule

// File: rtl/fifo9_rewind.sv
module fifo9_rewind
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_chain,
    input  logic       first_load,
    input  logic       xi,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       rt_n,
    input  logic [8:0] din,
    output logic [8:0] dout,
    output logic       dout_oe,
    output logic       empty,
    output logic       full,
    output logic       hf_xo
);
    initial assert (depth_ok(DEPTH));

    mode_e         mode;
    logic [1:0]    falls;
    req_t          req;
    logic          we, re, w_last, r_last, half;
    logic          wr_tok, rd_tok, xo;
    logic [AW-1:0] waddr, raddr;
    word_t         rdata;

    assign mode = mode_e'(mode_chain);

    strobe_edge #(.N(2)) u_edge (
        .clk(clk), .rst(rst), .strobe_n({rd_n, wr_n}), .fall(falls)
    );

    assign req.wr     = falls[0];
    assign req.rd     = falls[1];
    assign req.rewind = !rt_n && wr_n && rd_n;

    fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .mode(mode),
        .wr_tok(wr_tok), .rd_tok(rd_tok),
        .we(we), .re(re), .waddr(waddr), .raddr(raddr),
        .w_last(w_last), .r_last(r_last),
        .empty(empty), .full(full), .half(half)
    );

    fifo9_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(din),
        .re(re), .raddr(raddr), .rdata(rdata)
    );

    fifo9_xtok u_xtok (
        .clk(clk), .rst(rst), .mode(mode), .first_load(first_load), .xi(xi),
        .we(we), .re(re), .w_last(w_last), .r_last(r_last),
        .wr_tok(wr_tok), .rd_tok(rd_tok), .xo(xo)
    );

    assign dout    = rdata;
    assign dout_oe = !rd_n;
    assign hf_xo   = (mode == MODE_CHAIN) ? xo : half;
endmodule

// File: tb/fifo9_rewind_bench.sv
`timescale 1ns/100ps
module fifo9_rewind_bench;
    localparam int D = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_chain = 1'b0, first_load = 1'b1, xi = 1'b0;
    logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic dout_oe, empty, full, hf_xo;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fifo9_rewind #(.DEPTH(D)) u_fifo9_rewind (
        .clk(clk), .rst(rst), .mode_chain(mode_chain), .first_load(first_load),
        .xi(xi), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .empty(empty), .full(full), .hf_xo(hf_xo)
    );

    // Behavioural reference model
    int m_mem [D];
    int m_cnt, m_wpos, m_rpos, m_wtot, m_dout;
    bit m_pw, m_pr, m_xo, m_wtok, m_rtok;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_wpos = 0; m_rpos = 0; m_wtot = 0; m_dout = 0;
            m_pw = 1; m_pr = 1; m_xo = 0;
            m_wtok = first_load; m_rtok = first_load;
        end else begin
            bit wf, rf, we, re, rt;
            wf = m_pw && !wr_n;
            rf = m_pr && !rd_n;
            we = wf && (m_cnt < D) && (!mode_chain || m_wtok);
            re = rf && (m_cnt > 0) && (!mode_chain || m_rtok);
            rt = !mode_chain && !rt_n && wr_n && rd_n;
            m_xo = 0;
            if (we) begin
                m_mem[m_wpos] = din;
                if (m_wpos == D - 1) begin m_xo = 1; if (mode_chain) m_wtok = 0; end
                else if (mode_chain && xi && !m_wtok) m_wtok = 1;
                m_wpos = (m_wpos + 1) % D;
                if (m_wtot < D) m_wtot++;
            end else if (mode_chain && xi && !m_wtok) begin
                m_wtok = 1;
            end else if (mode_chain && xi) begin
                m_rtok = 1;
            end
            if (re) begin
                m_dout = m_mem[m_rpos];
                if (m_rpos == D - 1) begin m_xo = 1; if (mode_chain) m_rtok = 0; end
                m_rpos = (m_rpos + 1) % D;
            end
            if (rt) begin
                m_rpos = 0; m_cnt = m_wtot;
            end else begin
                m_cnt = m_cnt + int'(we) - int'(re);
            end
            m_pw = wr_n; m_pr = rd_n;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, 1 ns after the active edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            chk(empty == (m_cnt == 0), "R5 empty flag", empty, m_cnt == 0);
            chk(full == (m_cnt == D), "R4 full flag", full, m_cnt == D);
            if (mode_chain) chk(hf_xo == m_xo, "R10 token pulse", hf_xo, m_xo);
            else chk(hf_xo == (m_cnt >= D / 2), "R6 half flag", hf_xo, m_cnt >= D / 2);
            chk(int'(dout) == m_dout, "R3 read data", dout, m_dout);
            chk(dout_oe == !rd_n, "R7 output enable", dout_oe, !rd_n);
        end
    end

    task automatic do_reset(bit chain, bit first);
        @(negedge clk);
        mode_chain = chain; first_load = first; rst = 1;
        wr_n = 1; rd_n = 1; rt_n = 1; xi = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(int d);
        @(negedge clk); din = 9'(d); wr_n = 0;
        @(negedge clk); wr_n = 1;
    endtask

    task automatic rd();
        @(negedge clk); rd_n = 0;
        @(negedge clk); rd_n = 1;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(0, 1);
        @(negedge clk);
        chk(empty == 1, "R1 empty after reset", empty, 1);
        chk(full == 0, "R1 full after reset", full, 0);
        chk(hf_xo == 0, "R1 half after reset", hf_xo, 0);
        chk(dout == 0, "R1 dout after reset", dout, 0);

        // R2: a long write strobe stores one word
        @(negedge clk); din = 9'h1A5; wr_n = 0;
        repeat (4) @(negedge clk);
        wr_n = 1;
        for (int i = 1; i < 5; i++) wr(9'h100 + i);
        @(negedge clk);
        chk(m_cnt == 5 && !empty, "R2 single store per edge", m_cnt, 5);
        rd();
        chk(dout == 9'h1A5, "R3 first word out", dout, 9'h1A5);
        rd();
        chk(dout == 9'h101, "R3 fifo order", dout, 9'h101);

        // R8: rewind replays from the first word
        @(negedge clk); rt_n = 0;
        @(negedge clk); rt_n = 1;
        rd();
        chk(dout == 9'h1A5, "R8 replay first word", dout, 9'h1A5);
        // R9: rewind request while reading is not honoured
        @(negedge clk); rd_n = 0; rt_n = 0;
        @(negedge clk); rd_n = 1; rt_n = 1;
        rd();
        chk(dout == 9'h102, "R9 rewind refused with strobe low", dout, 9'h102);
        for (int i = 0; i < 2; i++) rd();
        // R5: reads while empty are refused
        rd(); rd();
        chk(empty == 1 && dout == 9'h104, "R5 underrun blocked", dout, 9'h104);

        // R4, R6: fill completely, overrun attempt, drain
        do_reset(0, 1);
        for (int i = 0; i < D; i++) begin
            wr((i * 7 + 3) & 9'h1FF);
            if (i == D / 2 - 2) chk(hf_xo == 0, "R6 below half", hf_xo, 0);
            if (i == D / 2 - 1) chk(hf_xo == 1, "R6 at half", hf_xo, 1);
        end
        chk(full == 1, "R4 full at depth", full, 1);
        wr(9'h0EE);
        chk(full == 1, "R4 overrun ignored", full, 1);
        for (int i = 0; i < D; i++) rd();
        chk(empty == 1 && dout == ((255 * 7 + 3) & 9'h1FF), "R4 last word intact", dout,
            (255 * 7 + 3) & 9'h1FF);

        // R10, R11: chain mode with the first-load device
        do_reset(1, 1);
        for (int i = 0; i < D - 1; i++) wr(i);
        @(negedge clk); din = 9'h055; wr_n = 0;
        @(negedge clk); wr_n = 1;
        chk(hf_xo == 1, "R10 pulse after last write", hf_xo, 1);
        @(negedge clk);
        chk(hf_xo == 0, "R10 pulse is one cycle", hf_xo, 0);
        for (int i = 0; i < D; i++) rd();
        chk(empty == 1, "R11 drained", empty, 1);
        wr(9'h033);
        chk(empty == 1, "R11 write without token ignored", empty, 1);
        @(negedge clk); rt_n = 0;
        @(negedge clk); rt_n = 1;
        @(negedge clk);
        chk(empty == 1, "R9 rewind ignored in chain mode", empty, 1);
        @(negedge clk); xi = 1;
        @(negedge clk); xi = 0;
        wr(9'h077);
        chk(empty == 0, "R11 xi grants write token", empty, 0);
        rd();
        chk(dout == 9'h055, "R11 read token still absent", dout, 9'h055);
        @(negedge clk); xi = 1;
        @(negedge clk); xi = 0;
        rd();
        chk(dout == 9'h077, "R11 xi grants read token", dout, 9'h077);

        // R11: device without first-load starts with no token
        do_reset(1, 0);
        wr(9'h011);
        chk(empty == 1, "R11 no token after reset", empty, 1);

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule